// File: doc/BRIEF.md
# Parallel Branch Dispatcher

This controller runs a search over a pool of identical puzzle-solving engines. Each engine applies the deduction rules on its own copy of a grid. When deduction stalls, the engine raises a branch request that names one cell and the set of digits still allowed there. The dispatcher keeps a table with one busy flag per engine. It checks that enough engines are idle to take every candidate. It then streams one copy command per candidate: the parent's grid goes to the lowest free engine, with the chosen cell forced to that digit, and the new engine is started. After the last copy the parent is released.

The dispatcher watches the level-held done and solved lines of every flagged engine. A failed engine is returned to the free pool. The first success ends the search: every other running engine is aborted, a solved flag is raised, and the winner's result word is steered to the output. Two other outcomes also end a run. If no engine remains active, the run is reported unsolvable. If a branch needs more engines than are idle, nothing is launched and the run ends with an out-of-room report.

Top module: `branch_dispatch`

## Requirements
- R1: After reset every busy flag is clear and every pulse and result output is low.
- R2: A start pulse while idle or finished starts only engine 0, sets only its flag, and clears all earlier results.
- R3: For an accepted branch, one copy command is issued per cycle in ascending digit order. Candidate mask bit i stands for digit i+1, and copy_val carries that digit in binary. Each command targets the lowest-numbered free engine, names the parent as source and carries the requested cell, and it pulses that engine's start.
- R4: In the cycle after the last copy, the parent receives a one-cycle acknowledge and its busy flag is cleared.
- R5: When several flagged engines request a branch in the same cycle, the lowest-numbered one is served first; the others keep waiting.
- R6: A flagged engine reporting done without solved has its flag cleared, and the freed slot is handed out again by later branches.
- R7: When flagged engines report solved, the lowest-numbered one wins: solved goes high, sol_idx names it, sol_data shows its result word, all other flagged engines get one abort pulse, and the table empties.
- R8: A branch whose candidate count exceeds the number of idle engines (counted after same-cycle releases) launches nothing: no_room goes high and every flagged engine is aborted.
- R9: When the last flagged engine is released with no solution, unsolvable goes high.
- R10: Branches may recur from any child engine while its siblings keep running.
- R11: solved, unsolvable and no_room are never high together, and each stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new run on engine 0 |
| eng_done | input | NUM_ENG | Per-engine finished level |
| eng_solved | input | NUM_ENG | Per-engine success level, valid with done |
| eng_br_req | input | NUM_ENG | Per-engine branch request level |
| eng_br_cell | input | NUM_ENG*CELL_W | Per-engine requested cell address |
| eng_br_cands | input | NUM_ENG*NDIG | Per-engine candidate digit mask |
| eng_data | input | NUM_ENG*DATA_W | Per-engine result word |
| eng_start | output | NUM_ENG | One-cycle start pulses |
| eng_abort | output | NUM_ENG | One-cycle abort pulses |
| br_ack | output | NUM_ENG | One-cycle branch acknowledge to the parent |
| copy_valid | output | 1 | Copy command valid |
| copy_src | output | IDX_W | Engine whose grid is copied |
| copy_dst | output | IDX_W | Engine receiving the grid |
| copy_cell | output | CELL_W | Cell forced in the copy |
| copy_val | output | VAL_W | Digit written into that cell |
| busy_map | output | NUM_ENG | Busy flag table |
| solved | output | 1 | A solution was found |
| sol_idx | output | IDX_W | Winning engine |
| sol_data | output | DATA_W | Winner's result word |
| unsolvable | output | 1 | Every engine failed |
| no_room | output | 1 | Branch refused for lack of engines |

## Verification
A corrupted busy flag shows up on busy_map in the same cycle. One cycle later it shows as a copy aimed at an engine that is already running, or as a premature unsolvable. A wrong candidate or priority pick shows on copy_val, copy_dst or copy_src in the first copy cycle. A wrong winner or abort mask shows on sol_idx, sol_data and eng_abort one cycle after the solved levels appear. Because every output is compared with a behavioural model on every clock, a divergence is caught in the cycle it first reaches a port.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    D_IDLE = 2'd0,
    D_RUN  = 2'd1,
    D_COPY = 2'd2,
    D_END  = 2'd3
  } disp_state_e;
endpackage

// File: rtl/disp_lowest.sv
module disp_lowest #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/disp_count.sv
module disp_count #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/branch_dispatch.sv
module branch_dispatch
  import disp_pkg::*;
#(
  parameter int NUM_ENG = 8,
  parameter int NDIG    = 9,
  parameter int CELL_W  = 7,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
  localparam int DIG_W  = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int VAL_W  = $clog2(NDIG + 1),
  localparam int FC_W   = $clog2(NUM_ENG + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_ENG-1:0]          eng_done,
  input  logic [NUM_ENG-1:0]          eng_solved,
  input  logic [NUM_ENG-1:0]          eng_br_req,
  input  logic [NUM_ENG*CELL_W-1:0]   eng_br_cell,
  input  logic [NUM_ENG*NDIG-1:0]     eng_br_cands,
  input  logic [NUM_ENG*DATA_W-1:0]   eng_data,
  output logic [NUM_ENG-1:0]          eng_start,
  output logic [NUM_ENG-1:0]          eng_abort,
  output logic [NUM_ENG-1:0]          br_ack,
  output logic                        copy_valid,
  output logic [IDX_W-1:0]            copy_src,
  output logic [IDX_W-1:0]            copy_dst,
  output logic [CELL_W-1:0]           copy_cell,
  output logic [VAL_W-1:0]            copy_val,
  output logic [NUM_ENG-1:0]          busy_map,
  output logic                        solved,
  output logic [IDX_W-1:0]            sol_idx,
  output logic [DATA_W-1:0]           sol_data,
  output logic                        unsolvable,
  output logic                        no_room
);

  // per-engine views of the flattened buses
  logic [NDIG-1:0]   cand_arr [NUM_ENG];
  logic [CELL_W-1:0] cell_arr [NUM_ENG];
  logic [DATA_W-1:0] data_arr [NUM_ENG];

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_unpack
    assign cand_arr[g] = eng_br_cands[g*NDIG +: NDIG];
    assign cell_arr[g] = eng_br_cell[g*CELL_W +: CELL_W];
    assign data_arr[g] = eng_data[g*DATA_W +: DATA_W];
  end

  // state
  disp_state_e         state_q, state_n;
  logic [NUM_ENG-1:0]  busy_q, busy_n;
  logic [IDX_W-1:0]    parent_q, parent_n;
  logic [NDIG-1:0]     rem_q, rem_n;
  logic [CELL_W-1:0]   cell_q, cell_n;
  logic [NUM_ENG-1:0]  start_n, abort_n, ack_n;
  logic                cv_n;
  logic [IDX_W-1:0]    src_n, dst_n;
  logic [CELL_W-1:0]   ccell_n;
  logic [VAL_W-1:0]    cval_n;
  logic                solved_n, uns_n, nroom_n;
  logic [IDX_W-1:0]    sidx_n;

  // event vectors
  logic [NUM_ENG-1:0]  win_vec, fail_vec, req_vec, busy_after;
  assign win_vec    = busy_q & eng_done & eng_solved;
  assign fail_vec   = busy_q & eng_done & ~eng_solved;
  assign req_vec    = busy_q & eng_br_req & ~eng_done;
  assign busy_after = busy_q & ~fail_vec;

  logic [IDX_W-1:0] win_idx, req_idx, free_idx;
  logic             win_any, req_any, free_any;
  logic [DIG_W-1:0] dig_idx;
  logic             dig_any;
  logic [VAL_W-1:0] need_cnt;
  logic [FC_W-1:0]  free_cnt;

  disp_lowest #(.W(NUM_ENG), .IW(IDX_W)) u_win  (.vec(win_vec), .idx(win_idx),  .any(win_any));
  disp_lowest #(.W(NUM_ENG), .IW(IDX_W)) u_req  (.vec(req_vec), .idx(req_idx),  .any(req_any));
  disp_lowest #(.W(NUM_ENG), .IW(IDX_W)) u_free (.vec(~busy_q), .idx(free_idx), .any(free_any));
  disp_lowest #(.W(NDIG),    .IW(DIG_W)) u_dig  (.vec(rem_q),   .idx(dig_idx),  .any(dig_any));
  disp_count  #(.W(NDIG),    .CW(VAL_W)) u_need (.vec(cand_arr[req_idx]), .cnt(need_cnt));
  disp_count  #(.W(NUM_ENG), .CW(FC_W))  u_fcnt (.vec(~busy_after),       .cnt(free_cnt));

  // next-state logic
  always_comb begin
    state_n  = state_q;
    busy_n   = busy_q;
    parent_n = parent_q;
    rem_n    = rem_q;
    cell_n   = cell_q;
    start_n  = '0;
    abort_n  = '0;
    ack_n    = '0;
    cv_n     = 1'b0;
    src_n    = '0;
    dst_n    = '0;
    ccell_n  = '0;
    cval_n   = '0;
    solved_n = solved;
    uns_n    = unsolvable;
    nroom_n  = no_room;
    sidx_n   = sol_idx;
    unique case (state_q)
      D_IDLE, D_END: begin
        if (start) begin
          busy_n     = NUM_ENG'(1);
          start_n    = NUM_ENG'(1);
          solved_n   = 1'b0;
          uns_n      = 1'b0;
          nroom_n    = 1'b0;
          sidx_n     = '0;
          state_n    = D_RUN;
        end
      end
      D_RUN: begin
        if (win_any) begin
          solved_n = 1'b1;
          sidx_n   = win_idx;
          abort_n  = busy_q & ~(NUM_ENG'(1) << win_idx);
          busy_n   = '0;
          state_n  = D_END;
        end else if (busy_after == '0) begin
          busy_n  = '0;
          uns_n   = 1'b1;
          state_n = D_END;
        end else if (req_any) begin
          if (int'(need_cnt) > int'(free_cnt)) begin
            nroom_n = 1'b1;
            abort_n = busy_after;
            busy_n  = '0;
            state_n = D_END;
          end else begin
            parent_n = req_idx;
            rem_n    = cand_arr[req_idx];
            cell_n   = cell_arr[req_idx];
            busy_n   = busy_after;
            state_n  = D_COPY;
          end
        end else begin
          busy_n = busy_after;
        end
      end
      D_COPY: begin
        if (!dig_any) begin
          ack_n[parent_q]  = 1'b1;
          busy_n[parent_q] = 1'b0;
          state_n          = D_RUN;
        end else if (free_any) begin
          cv_n              = 1'b1;
          src_n             = parent_q;
          dst_n             = free_idx;
          ccell_n           = cell_q;
          cval_n            = VAL_W'(dig_idx) + VAL_W'(1);
          start_n[free_idx] = 1'b1;
          busy_n[free_idx]  = 1'b1;
          rem_n[dig_idx]    = 1'b0;
        end
      end
      default: state_n = D_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= D_IDLE;
      busy_q     <= '0;
      parent_q   <= '0;
      rem_q      <= '0;
      cell_q     <= '0;
      eng_start  <= '0;
      eng_abort  <= '0;
      br_ack     <= '0;
      copy_valid <= 1'b0;
      copy_src   <= '0;
      copy_dst   <= '0;
      copy_cell  <= '0;
      copy_val   <= '0;
      solved     <= 1'b0;
      unsolvable <= 1'b0;
      no_room    <= 1'b0;
      sol_idx    <= '0;
    end else begin
      state_q    <= state_n;
      busy_q     <= busy_n;
      parent_q   <= parent_n;
      rem_q      <= rem_n;
      cell_q     <= cell_n;
      eng_start  <= start_n;
      eng_abort  <= abort_n;
      br_ack     <= ack_n;
      copy_valid <= cv_n;
      copy_src   <= src_n;
      copy_dst   <= dst_n;
      copy_cell  <= ccell_n;
      copy_val   <= cval_n;
      solved     <= solved_n;
      unsolvable <= uns_n;
      no_room    <= nroom_n;
      sol_idx    <= sidx_n;
    end
  end

  assign busy_map = busy_q;
  assign sol_data = solved ? data_arr[sol_idx] : '0;

  // checks on the dispatcher's own behaviour
  assert_copy_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |-> ($countones(eng_start) == 1 && (eng_start & ~busy_q) == '0 && copy_val != '0));

  assert_start_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start));

  assert_parent_freed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_ack != '0) |-> ($onehot0(br_ack) && (br_ack & busy_q) == '0));

  assert_winner_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(solved) |-> (!eng_abort[sol_idx] && busy_q == '0));

  assert_single_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({solved, unsolvable, no_room}));

  assert_refuse_no_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_room) |=> !copy_valid);

endmodule

// File: tb/branch_dispatch_test.sv
module branch_dispatch_test;
  localparam int K    = 8;
  localparam int NDIG = 9;
  localparam int CW   = 7;
  localparam int DW   = 8;
  localparam int IW   = 3;
  localparam int VW   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [K-1:0] done, slv, req;
  logic [NDIG-1:0] cands [K];
  logic [CW-1:0]   cellr [K];
  logic [K*CW-1:0]   cell_f;
  logic [K*NDIG-1:0] cand_f;
  logic [K*DW-1:0]   data_f;

  logic [K-1:0]  eng_start, eng_abort, br_ack, busy_map;
  logic          copy_valid, solved, unsolvable, no_room;
  logic [IW-1:0] copy_src, copy_dst, sol_idx;
  logic [CW-1:0] copy_cell;
  logic [VW-1:0] copy_val;
  logic [DW-1:0] sol_data;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < K; i++) begin
      cand_f[i*NDIG +: NDIG] = cands[i];
      cell_f[i*CW +: CW]     = cellr[i];
      data_f[i*DW +: DW]     = DW'(8'hA0 + i);
    end
  end

  branch_dispatch #(.NUM_ENG(K), .NDIG(NDIG), .CELL_W(CW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .eng_done(done), .eng_solved(slv), .eng_br_req(req),
    .eng_br_cell(cell_f), .eng_br_cands(cand_f), .eng_data(data_f),
    .eng_start(eng_start), .eng_abort(eng_abort), .br_ack(br_ack),
    .copy_valid(copy_valid), .copy_src(copy_src), .copy_dst(copy_dst),
    .copy_cell(copy_cell), .copy_val(copy_val), .busy_map(busy_map),
    .solved(solved), .sol_idx(sol_idx), .sol_data(sol_data),
    .unsolvable(unsolvable), .no_room(no_room)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int           mstate;
  logic [K-1:0] mbusy;
  int           mpar;
  logic [NDIG-1:0] mrem;
  int           mcell;
  logic [K-1:0] e_start, e_abort, e_ack;
  logic         e_cv, e_solved, e_uns, e_nr;
  int           e_src, e_dst, e_cell, e_val, e_idx;

  function automatic int first_set(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstate = 0; mbusy = '0; mpar = 0; mrem = '0; mcell = 0;
      e_start = '0; e_abort = '0; e_ack = '0; e_cv = 0;
      e_src = 0; e_dst = 0; e_cell = 0; e_val = 0;
      e_solved = 0; e_uns = 0; e_nr = 0; e_idx = 0;
    end else begin
      logic [K-1:0] win, fl, rq, ba;
      e_start = '0; e_abort = '0; e_ack = '0; e_cv = 0;
      e_src = 0; e_dst = 0; e_cell = 0; e_val = 0;
      win = mbusy & done & slv;
      fl  = mbusy & done & ~slv;
      rq  = mbusy & req & ~done;
      ba  = mbusy & ~fl;
      if (mstate == 0 || mstate == 3) begin
        if (start) begin
          mbusy = 1; e_start = 1; e_solved = 0; e_uns = 0; e_nr = 0; e_idx = 0; mstate = 1;
        end
      end else if (mstate == 1) begin
        if (win != 0) begin
          e_solved = 1; e_idx = first_set(32'(win));
          e_abort = mbusy & ~(K'(1) << e_idx); mbusy = 0; mstate = 3;
        end else if (ba == 0) begin
          mbusy = 0; e_uns = 1; mstate = 3;
        end else if (rq != 0) begin
          int p;
          p = first_set(32'(rq));
          if ($countones(cands[p]) > K - $countones(ba)) begin
            e_nr = 1; e_abort = ba; mbusy = 0; mstate = 3;
          end else begin
            mpar = p; mrem = cands[p]; mcell = int'(cellr[p]); mbusy = ba; mstate = 2;
          end
        end else begin
          mbusy = ba;
        end
      end else if (mstate == 2) begin
        if (mrem == 0) begin
          e_ack[mpar] = 1; mbusy[mpar] = 0; mstate = 1;
        end else begin
          int d, f;
          d = first_set(32'(mrem));
          f = first_set(32'(~mbusy));
          e_cv = 1; e_src = mpar; e_dst = f; e_cell = mcell; e_val = d + 1;
          e_start[f] = 1; mbusy[f] = 1; mrem[d] = 0;
        end
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      cmp(64'(busy_map), 64'(mbusy), "R6 busy flags");
      cmp(64'(eng_start), 64'(e_start), "R3 start pulses");
      cmp(64'(eng_abort), 64'(e_abort), "R7 abort pulses");
      cmp(64'(br_ack), 64'(e_ack), "R4 parent acknowledge");
      cmp({copy_valid, 8'(copy_src), 8'(copy_dst), 8'(copy_cell), 8'(copy_val)},
          {e_cv, 8'(e_src), 8'(e_dst), 8'(e_cell), 8'(e_val)}, "R3 copy command");
      cmp({solved, 8'(sol_idx), sol_data}, {e_solved, 8'(e_idx), e_solved ? DW'(8'hA0 + e_idx) : DW'(0)},
          "R7 solution output");
      cmp(64'(unsolvable), 64'(e_uns), "R9 unsolvable");
      cmp(64'(no_room), 64'(e_nr), "R8 no room");
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // engine behaviour: a start, abort or acknowledge clears that engine's levels
  task automatic tick();
    @(posedge clk);
    #1;
    for (int i = 0; i < K; i++) begin
      if (eng_start[i] || eng_abort[i] || br_ack[i]) begin
        done[i] = 0; slv[i] = 0; req[i] = 0;
      end
    end
  endtask

  initial begin
    rst_n = 0; start = 0; done = '0; slv = '0; req = '0;
    for (int i = 0; i < K; i++) begin
      cands[i] = '0; cellr[i] = CW'(10 + i);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    cmp(64'(busy_map), 0, "R1 flags after reset");
    cmp({eng_start, eng_abort, br_ack}, 0, "R1 pulses after reset");
    cmp({copy_valid, solved, unsolvable, no_room}, 0, "R1 results after reset");

    // run A: launch and branch
    start = 1; tick(); start = 0;
    cmp(64'(eng_start), 64'h1, "R2 only engine 0 started");
    cmp(64'(busy_map), 64'h1, "R2 flag 0 set");
    req[0] = 1; cands[0] = 9'h022;
    tick(); tick();
    cmp({copy_src, copy_dst, copy_val}, {3'd0, 3'd1, 4'd2}, "R3 first copy digit 2 to engine 1");
    cmp(64'(copy_cell), 64'd10, "R3 copy cell");
    tick();
    cmp({copy_dst, copy_val}, {3'd2, 4'd6}, "R3 second copy digit 6 to engine 2");
    tick();
    cmp(64'(br_ack), 64'h1, "R4 parent 0 acknowledged");
    cmp(64'(busy_map), 64'h06, "R4 parent flag cleared");

    // two simultaneous requests
    req[1] = 1; cands[1] = 9'h004;
    req[2] = 1; cands[2] = 9'h109;
    tick(); tick();
    cmp({copy_src, copy_dst, copy_val}, {3'd1, 3'd0, 4'd3}, "R5 lower requester served first");
    repeat (6) tick();
    cmp(64'(busy_map), 64'h1B, "R10 recursive branch from child engine");

    // failure release
    done[0] = 1;
    tick();
    cmp(64'(busy_map), 64'h1A, "R6 failed engine released");

    // refusal
    req[3] = 1; cands[3] = 9'h1FF;
    tick();
    cmp(64'(no_room), 1, "R8 branch refused");
    cmp(64'(eng_abort), 64'h1A, "R8 running engines aborted");
    tick(); tick();
    cmp(64'(no_room), 1, "R11 no_room held");

    // run B: unsolvable
    start = 1; tick(); start = 0;
    cmp({solved, unsolvable, no_room}, 0, "R11 results cleared by start");
    done[0] = 1;
    tick();
    cmp(64'(unsolvable), 1, "R9 all engines failed");
    tick();

    // run C: two winners in one cycle
    start = 1; tick(); start = 0;
    req[0] = 1; cands[0] = 9'h007;
    repeat (5) tick();
    cmp(64'(busy_map), 64'h0E, "R3 three children running");
    done[2] = 1; slv[2] = 1; done[3] = 1; slv[3] = 1;
    tick();
    cmp(64'(sol_idx), 2, "R7 lowest winner chosen");
    cmp(64'(sol_data), 64'hA2, "R7 winner data routed");
    cmp(64'(eng_abort), 64'h0A, "R7 other engines aborted");
    tick(); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule